// File: doc/BRIEF.md
# Sequential Two-Event Trigger Engine

This block turns three qualified event strobes into a single trigger pulse. It first waits for an arming event (A). Once armed, the first firing event (B) produces a one-cycle trigger. While armed, the engine can fall back to waiting for A again. The fallback happens on a cancel event (C) or when a programmable number of cycles has passed without B. Which of these applies is set by a mode input, and the fallback can also be turned off.

After every trigger the engine enters a holdoff window measured in clock cycles. During that window no event is acted on. When the window ends, the engine goes back to waiting for A. Dropping the enable input parks the engine in an idle state from any state. The event strobes come from upstream comparators and are one clock wide.

Top module: `seq_trig_engine`

## Requirements
- R1: While reset is asserted and after its release, `state_o` is 0 (idle) and `trig_o` is 0. The state encoding is idle=0, wait-arm=1, armed=2, holdoff=3.
- R2: With `en_i` high in idle, the state is wait-arm in the next cycle. With `en_i` low in any state, the state is idle in the next cycle and `trig_o` stays low.
- R3: In wait-arm, an A strobe moves the state to armed in the next cycle. A B strobe alone has no effect. A and B in the same cycle only arm: `trig_o` stays low.
- R4: In armed, a B strobe makes `trig_o` high for exactly the next cycle, and the state is holdoff in that same cycle. B takes priority over a C strobe or a timeout in the same cycle.
- R5: `rstsel_i` encodes the fallback: 0 none, 1 on C, 2 on timeout, 3 behaves as 0. With no fallback, armed persists until B arrives, and C strobes are ignored.
- R6: With `rstsel_i`=1, a C strobe without B in armed returns the state to wait-arm in the next cycle.
- R7: With `rstsel_i`=2, the engine stays armed for max(`tmo_i`,1) cycles at most. If no B arrives in that time, it returns to wait-arm. The cycle count restarts on every entry to armed.
- R8: Holdoff lasts max(`hold_i`,1) cycles and then returns to wait-arm. A, B and C strobes during holdoff are ignored.
- R9: The holdoff count is 32 bits wide by default, so limits above 16 bits are honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| evt_a_i | input | 1 | Arming event strobe |
| evt_b_i | input | 1 | Firing event strobe |
| evt_c_i | input | 1 | Cancel event strobe |
| rstsel_i | input | 2 | Fallback selection (0 none, 1 cancel event, 2 timeout, 3 none) |
| tmo_i | input | TMO_W (16) | Armed timeout in cycles |
| hold_i | input | HOLD_W (32) | Holdoff length in cycles |
| trig_o | output | 1 | One-cycle trigger pulse |
| state_o | output | 2 | Current engine state |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. These are B on the very last cycle of a timeout window, and B together with C, each landing in exactly the right state. The bench reaches them by sweeping the timeout and holdoff limits over small values and placing strobes at computed offsets from the arming cycle. A cycle-level reference model, written from the requirements, then runs alongside a long random strobe sequence in every fallback mode. A holdoff limit above 65535 confirms that the upper counter bits are used.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_FIRE  = 2'd2,
        ST_HOLD  = 2'd3
    } trig_state_e;

    typedef enum logic [1:0] {
        FB_NONE   = 2'd0,
        FB_CANCEL = 2'd1,
        FB_TIMER  = 2'd2,
        FB_ALT    = 2'd3
    } fallback_e;

    typedef struct packed {
        trig_state_e state;
        logic        trig;
    } fsm_regs_t;

endpackage

// File: rtl/seq_trig_span.sv
// Occupancy counter: counts cycles while run_i is high, clears when it
// drops, and flags the cycle that completes max(limit_i,1) cycles.
module seq_trig_span #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   elapsed;

    always_comb begin
        elapsed = {1'b0, cnt_q} + {1'b0, ONE};
        done_o  = run_i && (elapsed >= {1'b0, limit_i});
        if (!run_i)
            cnt_d = '0;
        else if (&cnt_q)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/seq_trig_fsm.sv
module seq_trig_fsm
    import seq_trig_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        en_i,
    input  logic        evt_a_i,
    input  logic        evt_b_i,
    input  logic        evt_c_i,
    input  logic [1:0]  rstsel_i,
    input  logic        tmo_done_i,
    input  logic        hold_done_i,
    output trig_state_e state_o,
    output logic        trig_o
);
    fsm_regs_t r_d, r_q;
    fallback_e fb;

    always_comb begin
        fb        = fallback_e'(rstsel_i);
        r_d       = r_q;
        r_d.trig  = 1'b0;
        if (!en_i) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: r_d.state = ST_ARM;
                ST_ARM: begin
                    if (evt_a_i) r_d.state = ST_FIRE;
                end
                ST_FIRE: begin
                    if (evt_b_i) begin
                        r_d.state = ST_HOLD;
                        r_d.trig  = 1'b1;
                    end else if (fb == FB_CANCEL && evt_c_i) begin
                        r_d.state = ST_ARM;
                    end else if (fb == FB_TIMER && tmo_done_i) begin
                        r_d.state = ST_ARM;
                    end
                end
                ST_HOLD: begin
                    if (hold_done_i) r_d.state = ST_ARM;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{state: ST_IDLE, trig: 1'b0};
        else         r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign trig_o  = r_q.trig;

endmodule

// File: rtl/seq_trig_engine.sv
module seq_trig_engine
    import seq_trig_pkg::*;
#(
    parameter int TMO_W  = 16,
    parameter int HOLD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              evt_a_i,
    input  logic              evt_b_i,
    input  logic              evt_c_i,
    input  logic [1:0]        rstsel_i,
    input  logic [TMO_W-1:0]  tmo_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              trig_o,
    output logic [1:0]        state_o
);
    trig_state_e st;
    logic        tmo_done, hold_done;
    logic        tmo_run, hold_run;

    assign tmo_run  = en_i && (st == ST_FIRE);
    assign hold_run = en_i && (st == ST_HOLD);

    seq_trig_span #(.W(TMO_W)) u_tmo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (tmo_run),
        .limit_i (tmo_i),
        .done_o  (tmo_done)
    );

    seq_trig_span #(.W(HOLD_W)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (hold_run),
        .limit_i (hold_i),
        .done_o  (hold_done)
    );

    seq_trig_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .evt_a_i     (evt_a_i),
        .evt_b_i     (evt_b_i),
        .evt_c_i     (evt_c_i),
        .rstsel_i    (rstsel_i),
        .tmo_done_i  (tmo_done),
        .hold_done_i (hold_done),
        .state_o     (st),
        .trig_o      (trig_o)
    );

    assign state_o = st;

endmodule

// File: rtl/seq_trig_chk.sv
module seq_trig_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       en_i,
    input logic       evt_a_i,
    input logic       evt_b_i,
    input logic       evt_c_i,
    input logic [1:0] rstsel_i,
    input logic       trig_o,
    input logic [1:0] state_o
);
    a_r2_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (state_o == 2'd0 && !trig_o));

    a_r3_arm_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_o == 2'd1 && evt_a_i) |=> (state_o == 2'd2 && !trig_o));

    a_r3_no_fire_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != 2'd2) |=> !trig_o);

    a_r4_fire_on_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_o == 2'd2 && evt_b_i) |=> (trig_o && state_o == 2'd3));

    a_r4_pulse_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);

    a_r6_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_o == 2'd2 && !evt_b_i && evt_c_i && rstsel_i == 2'd1)
        |=> state_o == 2'd1);

    a_r8_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd3) |=> (!trig_o && state_o != 2'd2));
endmodule

bind seq_trig_engine seq_trig_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .evt_a_i  (evt_a_i),
    .evt_b_i  (evt_b_i),
    .evt_c_i  (evt_c_i),
    .rstsel_i (rstsel_i),
    .trig_o   (trig_o),
    .state_o  (state_o)
);

// File: tb/sim_seq_trig_engine.sv
module sim_seq_trig_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, ea = 1'b0, eb = 1'b0, ec = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] tmo = 16'd0;
    logic [31:0] hold = 32'd0;
    logic        trig;
    logic [1:0]  st;

    int vecs = 0, errs = 0;
    int m_st = 0, m_cnt = 0;
    bit m_trig = 0;

    always #10 clk = ~clk;

    seq_trig_engine u0 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .evt_a_i(ea), .evt_b_i(eb),
        .evt_c_i(ec), .rstsel_i(mode), .tmo_i(tmo), .hold_i(hold),
        .trig_o(trig), .state_o(st)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, advance reference model, compare after the edge
    task automatic tick(input bit e, input bit a, input bit b, input bit c, input string tag);
        int nst;
        longint lim;
        bit ntrig;
        en = e; ea = a; eb = b; ec = c;
        nst = m_st; ntrig = 0;
        if (!e) nst = 0;
        else case (m_st)
            0: nst = 1;
            1: if (a) nst = 2;
            2: begin
                lim = (tmo == 0) ? 1 : tmo;
                if (b) begin nst = 3; ntrig = 1; end
                else if (mode == 2'd1 && c) nst = 1;
                else if (mode == 2'd2 && m_cnt + 1 >= lim) nst = 1;
            end
            default: begin
                lim = (hold == 0) ? 1 : hold;
                if (m_cnt + 1 >= lim) nst = 1;
            end
        endcase
        m_cnt = (nst == m_st) ? m_cnt + 1 : 0;
        m_st = nst; m_trig = ntrig;
        @(posedge clk); #1;
        chk(st == 2'(m_st), {tag, " state"}, st, m_st);
        chk(trig == m_trig, {tag, " trig"}, trig, m_trig);
    endtask

    task automatic go_armed(input string tag);
        tick(0, 0, 0, 0, tag);
        tick(1, 0, 0, 0, tag);
        tick(1, 1, 0, 0, tag);
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        int n;
        #5;
        chk(st == 2'd0 && trig == 1'b0, "R1 reset state", st, 0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(st == 2'd0 && trig == 1'b0, "R1 after release", st, 0);

        // R2 enable and disable
        tick(1, 0, 0, 0, "R2 enable");
        tick(0, 0, 0, 0, "R2 disable");
        go_armed("R2 disable armed");
        tick(0, 0, 1, 0, "R2 disable beats b");

        // R3 arming rules
        tick(1, 0, 0, 0, "R3");
        tick(1, 0, 1, 0, "R3 b alone ignored");
        tick(1, 1, 1, 0, "R3 a+b only arms");
        chk(trig == 1'b0, "R3 no trig on a+b", trig, 0);
        tick(1, 0, 1, 0, "R4 b fires");
        hold = 32'd3;
        repeat (3) tick(1, 1, 1, 1, "R8 events ignored in holdoff");

        // R5 no fallback: modes 0 and 3
        for (int md = 0; md < 4; md += 3) begin
            mode = 2'(md); tmo = 16'd2;
            go_armed("R5");
            repeat (20) tick(1, 0, 0, 1, "R5 c ignored");
            chk(st == 2'd2, "R5 still armed", st, 2);
        end

        // R6 cancel and R4 priority of b over c
        mode = 2'd1;
        go_armed("R6");
        tick(1, 0, 0, 1, "R6 cancel");
        chk(st == 2'd1, "R6 back to wait-arm", st, 1);
        tick(1, 1, 0, 0, "R6 rearm");
        tick(1, 0, 1, 1, "R4 b over c");
        chk(trig == 1'b1, "R4 trig with b+c", trig, 1);
        hold = 32'd1;
        tick(1, 0, 0, 0, "R8");

        // R7 timeout sweep, plus b on the final window cycle
        mode = 2'd2;
        for (int d = 0; d <= 6; d++) begin
            tmo = 16'(d);
            go_armed("R7");
            n = 0;
            while (st == 2'd2 && n < 50) begin tick(1, 0, 0, 0, "R7 sweep"); n++; end
            chk(n == ((d == 0) ? 1 : d), "R7 armed span", n, (d == 0) ? 1 : d);
            go_armed("R4");
            for (int k = 1; k < ((d == 0) ? 1 : d); k++) tick(1, 0, 0, 0, "R7");
            tick(1, 0, 1, 0, "R4 b on last timeout cycle");
            chk(trig == 1'b1, "R4 b beats timeout", trig, 1);
        end

        // R8 holdoff sweep
        for (int h = 0; h <= 6; h++) begin
            hold = 32'(h); mode = 2'd0;
            go_armed("R8");
            tick(1, 0, 1, 0, "R8 fire");
            n = 0;
            while (st == 2'd3 && n < 50) begin tick(1, 1, 1, 1, "R8 sweep"); n++; end
            chk(n == ((h == 0) ? 1 : h), "R8 holdoff span", n, (h == 0) ? 1 : h);
        end

        // R9 holdoff limit beyond 16 bits
        hold = 32'h0001_0003;
        go_armed("R9");
        tick(1, 0, 1, 0, "R9 fire");
        n = 0;
        while (st == 2'd3 && n < 70000) begin tick(1, 0, 0, 0, "R9 hold"); n++; end
        chk(n == 65539, "R9 wide holdoff span", n, 65539);

        // random strobes in every fallback mode against the model
        for (int md = 0; md < 4; md++) begin
            mode = 2'(md); tmo = 16'(md + 1); hold = 32'(3 - md);
            for (int i = 0; i < 1500; i++)
                tick(($urandom % 32) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
                     ($urandom % 4) == 0, "R4 R6 R7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule